// File: doc/BRIEF.md
# Periodic Divider-Count Clock Calibrator

This block divides a 32768 Hz oscillator, delivered as a clock enable, down to a one-second tick. It trims the rate digitally and needs no analog tuning. The chain has two stages. A prescaler turns the oscillator pulses into an intermediate pulse stream, 256 oscillator pulses per stage pulse. A second stage counts those pulses into seconds. To correct the rate, the calibrator changes the intermediate stream. A blanked pulse is one the second stage does not count, which stretches that second. A split pulse is one the second stage counts twice, which shortens that second.

A 6-bit control word sets the correction. Bit 5 selects the direction and bits 4..0 hold a magnitude from 0 to 31. Each calibration period lasts `PERIOD_TICKS` seconds (3840 by default, which is 64 minutes). In each period the block adjusts `ADJ_PER_LSB` times the magnitude seconds by one pulse each. These are the first seconds of the period, one adjusted pulse per second. The control word is sampled only when a period closes. A frequency-test output gives a square wave taken from the uncorrected prescaler.

Top module: `osc_trim_divider`

## Requirements
- R1: While reset is asserted, `sec_tick` and `ftest_out` are 0. The period that begins at reset release carries no adjustment, whatever `trim_ctl` holds.
- R2: All counting advances only on clock cycles with `osc_en` high. While `osc_en` is low, no tick occurs and `ftest_out` holds its value. A second is measured in `osc_en` pulses, however those pulses are spaced.
- R3: With magnitude 0 (`trim_ctl` = 6'h00), every second lasts `DIV1*DIV2` enable pulses.
- R4: `ftest_out` toggles once every `DIV1` enable pulses. Calibration does not change this.
- R5: With `trim_ctl[5]` = 0 and magnitude m > 0, the first K = `ADJ_PER_LSB*m` seconds of the period each last `(DIV2+1)*DIV1` pulses, because one stage pulse is blanked. The other seconds last the nominal time, and no second loses more than one stage pulse.
- R6: With `trim_ctl[5]` = 1 and magnitude m > 0, the first K seconds of the period each last `(DIV2-1)*DIV1` pulses, because one stage pulse is split. The other seconds are nominal.
- R7: A period spans `PERIOD_TICKS` ticks. While the control word does not change, the same pattern repeats in every period.
- R8: The block captures `trim_ctl` in the cycle that produces the period-closing tick. A change later in the period has no effect on the running period and applies from the first second of the next one.
- R9: `sec_tick` is a pulse one clock cycle long.
- R10: Magnitude 31 adjusts `31*ADJ_PER_LSB` seconds per period, in either direction.
- R11: The direction bit with magnitude 0 (6'h20) adjusts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One cycle high per oscillator pulse |
| trim_ctl | input | 6 | Bit 5: 1 speeds the clock up, 0 slows it down; bits 4..0: magnitude |
| sec_tick | output | 1 | One-cycle pulse per corrected second |
| ftest_out | output | 1 | Square wave toggling every `DIV1` oscillator pulses |

## Verification
Three events land on the same enabled edge: the tick that closes a period, the capture of the new control word, and the arming of the first adjustment of the next period. The bench drives magnitude 31 with 62 adjusted seconds, which leaves almost no nominal seconds before the boundary. It then follows with values of the opposite direction and of zero, and changes `trim_ctl` partway through every period. The check is the enable-pulse length of every second on both sides of each boundary. Each second must match the value captured at the boundary, never the value written later in the period.

// File: rtl/osc_trim_divider.sv
module osc_trim_divider #(
  parameter int DIV1         = 256,
  parameter int DIV2         = 128,
  parameter int PERIOD_TICKS = 3840,
  parameter int ADJ_PER_LSB  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic [5:0] trim_ctl,
  output logic       sec_tick,
  output logic       ftest_out
);
  localparam int PW   = (DIV1 > 1) ? $clog2(DIV1) : 1;
  localparam int SW   = $clog2(DIV2) + 1;
  localparam int TW   = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam int MAXN = 31 * ADJ_PER_LSB;
  localparam int NW   = $clog2(MAXN + 1);

  logic [PW-1:0] pre_q;
  logic [SW-1:0] sec_q, sum;
  logic [TW-1:0] per_q;
  logic [NW-1:0] adj_left, n_new;
  logic          armed, act_pos;
  logic          stage_p, adj_now, wrap_s, per_end;
  logic [1:0]    inc;

  assign stage_p = osc_en && (pre_q == PW'(DIV1 - 1));
  assign adj_now = stage_p && armed;
  assign inc     = !stage_p ? 2'd0 : !adj_now ? 2'd1 : act_pos ? 2'd2 : 2'd0;
  assign sum     = sec_q + SW'(inc);
  assign wrap_s  = sum >= SW'(DIV2);
  assign per_end = per_q == TW'(PERIOD_TICKS - 1);
  assign n_new   = NW'(int'(trim_ctl[4:0]) * ADJ_PER_LSB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      ftest_out <= 1'b0;
    end else if (osc_en) begin
      pre_q <= stage_p ? '0 : pre_q + PW'(1);
      if (stage_p) ftest_out <= !ftest_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q    <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_q    <= wrap_s ? sum - SW'(DIV2) : sum;
      sec_tick <= wrap_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q    <= '0;
      adj_left <= '0;
      armed    <= 1'b0;
      act_pos  <= 1'b0;
    end else begin
      if (adj_now) begin
        armed    <= 1'b0;
        adj_left <= adj_left - NW'(1);
      end
      if (wrap_s) begin
        if (per_end) begin
          per_q    <= '0;
          act_pos  <= trim_ctl[5];
          adj_left <= n_new;
          armed    <= n_new != '0;
        end else begin
          per_q <= per_q + TW'(1);
          armed <= adj_left != '0;
        end
      end
    end
  end
endmodule

module osc_trim_divider_chk #(
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_en,
  input logic          sec_tick,
  input logic          ftest_out,
  input logic          act_pos,
  input logic [LW-1:0] adj_left
);
  p_tick_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(osc_en));
  p_ft_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ftest_out) |-> $past(osc_en));
  p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  p_sign_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_pos) |-> sec_tick);
  p_budget_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_left > $past(adj_left)) |-> sec_tick);
  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_left < $past(adj_left)) |-> (adj_left == $past(adj_left) - LW'(1)));
endmodule

bind osc_trim_divider osc_trim_divider_chk #(.LW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .sec_tick(sec_tick),
  .ftest_out(ftest_out), .act_pos(act_pos), .adj_left(adj_left)
);

// File: tb/osc_trim_divider_tb.sv
module osc_trim_divider_tb;
  localparam int D1  = 4;
  localparam int D2  = 8;
  localparam int PT  = 64;
  localparam int AL  = 2;
  localparam int NOM = D1 * D2;
  localparam logic [5:0] VEC [6] = '{6'h00, 6'h03, 6'h23, 6'h20, 6'h3F, 6'h1F};

  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b1;
  logic [5:0] trim_ctl = 6'h05;
  logic sec_tick, ftest_out;

  int checks = 0, fails = 0, cyc = 0;
  int tick_no = 0, en_tick = 0, en_ft = 0, ft_toggles = 0, ft_bad = 0, dbl = 0;
  logic ft_prev = 1'b0, prev_tick = 1'b0;
  int lens [0:1023];

  always #2 clk = !clk;

  osc_trim_divider #(.DIV1(D1), .DIV2(D2), .PERIOD_TICKS(PT), .ADJ_PER_LSB(AL)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .trim_ctl(trim_ctl),
    .sec_tick(sec_tick), .ftest_out(ftest_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
    if (rst_n) begin
      if (sec_tick) begin
        tick_no++;
        if (tick_no < 1024) lens[tick_no] = en_tick;
        en_tick = 0;
        if (prev_tick) dbl++;
      end
      prev_tick = sec_tick;
      if (ftest_out != ft_prev) begin
        ft_toggles++;
        if (ft_toggles > 1 && en_ft != D1) ft_bad++;
        en_ft = 0;
        ft_prev = ftest_out;
      end
      if (osc_en) begin
        en_tick++;
        en_ft++;
      end
    end
  end

  task automatic wait_ticks(input int n);
    while (tick_no < n) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic check_period(input int p, input logic [5:0] val, input string req);
    int k, l, bad, fa, fe, tot, etot;
    k = AL * int'(val[4:0]);
    l = (k == 0) ? NOM : val[5] ? (D2 - 1) * D1 : (D2 + 1) * D1;
    bad = 0; fa = 0; fe = 0; tot = 0; etot = 0;
    for (int i = 1; i <= PT; i++) begin
      int idx, e;
      if (p == 0 && i == 1) continue;
      idx = p * PT + i;
      e = (i <= k) ? l : NOM;
      tot += lens[idx];
      etot += e;
      if (lens[idx] != e) begin
        if (bad == 0) begin fa = lens[idx]; fe = e; end
        bad++;
      end
    end
    chk(bad == 0, {req, " per-second length"}, fa, fe);
    chk(tot == etot, {req, " period total"}, tot, etot);
  endtask

  function automatic string tag_of(input logic [5:0] v);
    if (v[4:0] == 5'd31) return "R10+R8";
    if (v[4:0] == 5'd0) return v[5] ? "R11+R8" : "R3+R8";
    return v[5] ? "R6+R8" : "R5+R8";
  endfunction

  initial begin
    int t0;
    logic f0;
    repeat (5) @(negedge clk);
    chk(sec_tick == 1'b0, "R1 tick in reset", int'(sec_tick), 0);
    chk(ftest_out == 1'b0, "R1 ftest in reset", int'(ftest_out), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    wait_ticks(PT / 2);
    trim_ctl = VEC[0];
    wait_ticks(PT);
    check_period(0, 6'h00, "R1");

    for (int v = 0; v < 6; v++) begin
      wait_ticks((v + 1) * PT + PT / 2);
      trim_ctl = (v == 5) ? 6'h02 : VEC[v + 1];
      wait_ticks((v + 2) * PT);
      check_period(v + 1, VEC[v], tag_of(VEC[v]));
    end

    wait_ticks(8 * PT);
    check_period(7, 6'h02, "R7 first");
    wait_ticks(9 * PT);
    check_period(8, 6'h02, "R7 repeat");

    wait_ticks(9 * PT + 10);
    repeat (7) @(posedge clk);
    #1;
    osc_en = 1'b0;
    t0 = tick_no;
    f0 = ftest_out;
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk(tick_no == t0, "R2 no tick while idle", tick_no, t0);
    chk(ftest_out == f0, "R2 ftest holds while idle", int'(ftest_out), int'(f0));
    @(posedge clk); #1;
    for (int i = 0; i < 40; i++) begin
      osc_en = i[0];
      @(posedge clk); #1;
    end
    osc_en = 1'b1;
    wait_ticks(9 * PT + 12);
    chk(lens[9 * PT + 11] == NOM, "R2 gated second length", lens[9 * PT + 11], NOM);
    chk(lens[9 * PT + 12] == NOM, "R2 second after gating", lens[9 * PT + 12], NOM);

    chk(ft_toggles > 100, "R4 ftest activity", ft_toggles, 100);
    chk(ft_bad == 0, "R4 ftest half period", ft_bad, 0);
    chk(dbl == 0, "R9 single-cycle tick", dbl, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule